// File: doc/BRIEF.md
# Calibrated SAR Conversion Slice Controller

This block sequences one successive-approximation conversion slice through a fixed frame of sixteen clock cycles. The first three cycles of each frame drive the analog front end through zero-reference sampling, an offset (auto-zero) comparison and a gain (auto-calibrate) comparison. A single cycle then captures the input. Eleven cycles resolve the result one bit at a time, most significant bit first. The last cycle presents the finished code together with a one-cycle transfer strobe.

The slice waits in an idle state after reset until a phase-start strobe arrives, then runs frames back to back with no further strobe. Several slices can share one input clock, with their start strobes staggered by one cycle each, so that the input is captured on every cycle. The comparator decision comes in on one bit. During each bit trial the controller drives a DAC code, and the comparator tells it whether the input lies below that level. The two calibration comparisons are latched into flag outputs for downstream correction logic.

Top module: `sar_slice_ctrl`

## Requirements
- R1: After a synchronous reset, and for as long as no start strobe is seen, all control strobes, `dac_code`, `result`, `xfer_valid`, `az_flag` and `cal_flag` are 0.
- R2: A start strobe sampled high at a clock edge while idle makes the next cycle frame cycle 1. A frame lasts 16 cycles, and frames repeat with no further strobe.
- R3: Within a frame exactly one control is high per cycle: `ref_zero_en` in cycle 1, `autozero_en` in cycle 2, `autocal_en` in cycle 3, `sample_en` in cycle 4, `trial_en` in cycles 5 to 15 and `xfer_valid` in cycle 16.
- R4: `az_flag` takes the comparator value seen in cycle 2, and `cal_flag` takes the value seen in cycle 3. Each holds that value until the same cycle of the next frame.
- R5: Bit trials run MSB first: cycle 4+j tests bit 11-j. During a trial, `dac_code` equals the bits already resolved, with the bit under test set to 1 and all lower bits 0. Outside trials, `dac_code` is 0.
- R6: A comparator value of 1 (input below the DAC level) clears the bit under test at the end of its cycle, and 0 keeps it. For an input level v in 0..2047 with an ideal comparator, the result equals v.
- R7: `result` changes only on the edge that enters cycle 16. `xfer_valid` is a single-cycle pulse in cycle 16.
- R8: A start strobe that arrives while a frame is running is ignored, and the frame position is unchanged.
- R9: A reset asserted in the middle of a frame returns the slice to the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Phase-start strobe, used only while idle |
| cmp_below | input | 1 | Comparator decision, 1 = input below DAC level |
| ref_zero_en | output | 1 | Zero-reference sampling control (cycle 1) |
| autozero_en | output | 1 | Auto-zero comparison control (cycle 2) |
| autocal_en | output | 1 | Auto-calibrate comparison control (cycle 3) |
| sample_en | output | 1 | Input sample control (cycle 4) |
| trial_en | output | 1 | Bit trial in progress (cycles 5 to 15) |
| dac_code | output | 11 | Trial DAC code |
| az_flag | output | 1 | Latched auto-zero comparison |
| cal_flag | output | 1 | Latched auto-calibrate comparison |
| result | output | 11 | Converted code |
| xfer_valid | output | 1 | Transfer strobe (cycle 16) |

## Verification
The controls and `dac_code` are decoded from the cycle count, so they are due in the same cycle as the frame cycle they belong to. The first frame cycle follows the edge that samples `start`. The flags appear one cycle after their comparison cycle and are checked in cycle 4. `result` and `xfer_valid` are registered at the end of cycle 15, so they are checked in cycle 16, and the previous result is checked to be still present in cycles 1 and 15. The bench counts frame cycles from the start strobe by itself and samples every output on the falling edge, so each check lands inside the cycle it names.

// File: rtl/sar_slice_ctrl.sv
module sar_slice_ctrl #(
  parameter int RES_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_below,
  output logic             ref_zero_en,
  output logic             autozero_en,
  output logic             autocal_en,
  output logic             sample_en,
  output logic             trial_en,
  output logic [RES_W-1:0] dac_code,
  output logic             az_flag,
  output logic             cal_flag,
  output logic [RES_W-1:0] result,
  output logic             xfer_valid
);
  localparam int FRAME_LEN   = RES_W + 5;
  localparam int SLOT_W      = $clog2(FRAME_LEN + 1);
  localparam int SMP_SLOT    = 4;
  localparam int FIRST_TRIAL = 5;
  localparam int LAST_TRIAL  = RES_W + 4;

  logic [SLOT_W-1:0] slot;
  logic [RES_W-1:0]  code;
  logic [RES_W-1:0]  mask;
  logic [RES_W-1:0]  code_nxt;

  assign ref_zero_en = (slot == SLOT_W'(1));
  assign autozero_en = (slot == SLOT_W'(2));
  assign autocal_en  = (slot == SLOT_W'(3));
  assign sample_en   = (slot == SLOT_W'(SMP_SLOT));
  assign trial_en    = (slot >= SLOT_W'(FIRST_TRIAL)) && (slot <= SLOT_W'(LAST_TRIAL));

  assign mask     = trial_en ? (RES_W'(1) << (SLOT_W'(LAST_TRIAL) - slot)) : '0;
  assign dac_code = trial_en ? (code | mask) : '0;
  assign code_nxt = cmp_below ? code : (code | mask);

  always_ff @(posedge clk) begin
    if (rst)                              slot <= '0;
    else if (slot == '0)                  slot <= start ? SLOT_W'(1) : '0;
    else if (slot == SLOT_W'(FRAME_LEN))  slot <= SLOT_W'(1);
    else                                  slot <= slot + SLOT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code       <= '0;
      result     <= '0;
      xfer_valid <= 1'b0;
      az_flag    <= 1'b0;
      cal_flag   <= 1'b0;
    end else begin
      xfer_valid <= (slot == SLOT_W'(LAST_TRIAL));
      if (autozero_en) az_flag  <= cmp_below;
      if (autocal_en)  cal_flag <= cmp_below;
      if (sample_en)     code <= '0;
      else if (trial_en) code <= code_nxt;
      if (slot == SLOT_W'(LAST_TRIAL)) result <= code_nxt;
    end
  end
endmodule

// File: rtl/sar_slice_ctrl_chk.sv
module sar_slice_ctrl_chk #(
  parameter int RES_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_zero_en,
  input logic             autozero_en,
  input logic             autocal_en,
  input logic             sample_en,
  input logic             trial_en,
  input logic [RES_W-1:0] dac_code,
  input logic             az_flag,
  input logic [RES_W-1:0] result,
  input logic             xfer_valid
);
  AST_ONE_CONTROL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ref_zero_en, autozero_en, autocal_en, sample_en, trial_en, xfer_valid})); // R3
  AST_REFZ_THEN_AZ: assert property (@(posedge clk) disable iff (rst)
    ref_zero_en |=> autozero_en); // R3
  AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> (trial_en && dac_code == (RES_W'(1) << (RES_W - 1)))); // R5
  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |=> !xfer_valid); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!xfer_valid && !$past(rst)) |-> $stable(result)); // R7
  AST_AZ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(autozero_en) && !$past(rst)) |-> $stable(az_flag)); // R4
endmodule

bind sar_slice_ctrl sar_slice_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .ref_zero_en(ref_zero_en), .autozero_en(autozero_en),
  .autocal_en(autocal_en), .sample_en(sample_en), .trial_en(trial_en),
  .dac_code(dac_code), .az_flag(az_flag), .result(result), .xfer_valid(xfer_valid)
);

// File: tb/test_sar_slice_ctrl.sv
module test_sar_slice_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {11'd0,    1'b1, 1'b0},
    {11'd2047, 1'b0, 1'b1},
    {11'd1024, 1'b1, 1'b1},
    {11'd1023, 1'b0, 1'b0},
    {11'd1,    1'b1, 1'b0},
    {11'd682,  1'b0, 1'b1},
    {11'd1365, 1'b1, 1'b1},
    {11'd2046, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, cmp_below;
  logic ref_zero_en, autozero_en, autocal_en, sample_en, trial_en, az_flag, cal_flag, xfer_valid;
  logic [10:0] dac_code, result;
  logic [10:0] vin = '0;
  logic az_v = 1'b0, cal_v = 1'b0;
  logic [10:0] prev_res = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    cmp_below = trial_en ? (vin < dac_code) : autozero_en ? az_v : autocal_en ? cal_v : 1'b0;

  sar_slice_ctrl i_sar_slice_ctrl (
    .clk(clk), .rst(rst), .start(start), .cmp_below(cmp_below),
    .ref_zero_en(ref_zero_en), .autozero_en(autozero_en), .autocal_en(autocal_en),
    .sample_en(sample_en), .trial_en(trial_en), .dac_code(dac_code),
    .az_flag(az_flag), .cal_flag(cal_flag), .result(result), .xfer_valid(xfer_valid)
  );

  wire [5:0] ctl = {ref_zero_en, autozero_en, autocal_en, sample_en, trial_en, xfer_valid};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_ctl(int k);
    case (k)
      1: return 6'b100000;
      2: return 6'b010000;
      3: return 6'b001000;
      4: return 6'b000100;
      16: return 6'b000001;
      default: return 6'b000010;
    endcase
  endfunction

  task automatic chk_idle(string req);
    chk(req, {ctl, dac_code, result, az_flag, cal_flag}, '0);
  endtask

  // Called at the falling edge inside frame cycle 1; returns at cycle 1 of the next frame.
  task automatic run_frame(logic [10:0] v, logic az, logic cal, bit poke);
    vin = v; az_v = az; cal_v = cal;
    for (int k = 1; k <= 16; k++) begin
      chk((poke && k > 7) ? "R8 controls" : "R3 controls", ctl, exp_ctl(k));
      if (k == 1 || k == 15) chk("R7 result held", result, prev_res);
      if (k == 4) chk("R4 flags", {az_flag, cal_flag}, {az, cal});
      if (k == 5) chk("R5 msb trial", dac_code, 11'h400);
      if (k == 6) chk("R5 second trial", dac_code, (v & 11'h400) | 11'h200);
      if (k == 16) chk("R6 result", result, v);
      start = (poke && k == 7);
      @(negedge clk);
    end
    start = 1'b0;
    prev_res = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_idle("R1 reset state");
    repeat (20) @(negedge clk);
    chk_idle("R1 idle without start");
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 first cycle after start", ctl, 6'b100000);
    for (int i = 0; i < NV; i++)
      run_frame(VEC[i][12:2], VEC[i][1], VEC[i][0], i == 3);
    chk("R2 frames repeat", ctl, 6'b100000);
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_idle("R9 mid-frame reset");
    repeat (5) @(negedge clk);
    chk_idle("R9 stays idle");
    prev_res = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    run_frame(11'd1500, 1'b1, 1'b0, 1'b0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule